// File: doc/BRIEF.md
# Divide-by-Three Clock Generator

This block derives a processor clock and a peripheral clock from one fast source clock. A static strap input picks the source: either the crystal-derived clock or an external frequency input. The processor clock runs at one third of the source rate and is high for one source period out of three. The peripheral clock runs at half the processor rate with equal high and low times. The crystal clock also leaves the block unchanged on a buffered oscillator output.

A clear input puts both divided clocks into a known phase. The block first passes this input through two flip-flops clocked by the selected source. While the synchronized clear is high, the divider sits in its terminal state and both divided clocks are low. When the clear is released, every generator that saw the same release reaches the same phase on the same source edge. Several generators can therefore be lined up by one shared pulse.

All divided outputs come straight from flip-flops clocked by the selected source. The strap must not change while the block is running. The oscillator output is a plain wire copy of the crystal clock.

Top module: `clkdiv3_gen`

## Requirements
- R1: The processor clock has exactly one rising edge for every three rising edges of the selected source clock, as long as the clear is low.
- R2: The processor clock is high for one source period and low for the following two. After reset is released, it is high after the first selected source edge and low after the next two. This gives the pattern 1,0,0 repeating.
- R3: The peripheral clock changes value only on the source edge where the processor clock goes high. It holds each level for three source periods. It comes out of reset or clear low and is high after the first processor high edge.
- R4: With the strap input at 0, only the crystal clock advances the outputs. With the strap at 1, only the external clock does, and edges of the crystal clock then leave the processor and peripheral clocks unchanged.
- R5: The clear input is registered twice in the selected clock domain. It is high when sampled at edge t. From edge t+2 on, both divided clocks are low, and they stay low for as long as the clear stays high.
- R6: The clear input is low when sampled at edge t, after having been high. Both divided clocks stay low after edges t and t+1. Both are high after edge t+2, and the R2/R3 pattern then continues from its start, whatever the phase before the clear.
- R7: A clear pulse high for just two source periods fully re-phases the outputs. Both clocks are high on the third edge after the pulse ends.
- R8: The oscillator output equals the crystal clock at all times, whatever the strap, clear or reset.
- R9: While reset (active low) is asserted, the processor and peripheral clocks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xtalClk | input | 1 | Crystal-derived fast clock |
| extClk | input | 1 | External frequency input |
| srcSel | input | 1 | Static strap: 0 selects crystal clock, 1 selects external clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncClr | input | 1 | Phase clear, active high, synchronized internally by two flops |
| oscOut | output | 1 | Buffered copy of the crystal clock |
| cpuClk | output | 1 | Processor clock, one third of source, 1/3 high |
| periClk | output | 1 | Peripheral clock, half of processor clock, 50% duty |

## Verification
Some properties are checked on every selected source edge. The processor clock is never high for two periods in a row. The divide counter stays within its three states. The peripheral clock changes only when the processor clock rises. A synchronized clear drives both clocks low on the next edge. Other behaviour can only be shown by the bench scenarios. These are the exact 1,0,0 pattern after reset, the two-edge clear latency in each direction, and that a two-period pulse is enough. They also show that the unselected clock source has no effect and that the oscillator output follows the crystal clock.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic hold;   // synchronized clear active
    logic wrap;   // counter leaves terminal state on next edge
  } divStrobe_t;
endpackage

// File: rtl/clkdiv3_ctrl.sv
module clkdiv3_ctrl
  import clkdiv3_pkg::*;
#(
  parameter int DIVIDE      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncClr,
  output divStrobe_t strobe
);
  localparam int CW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIVIDE - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          cnt;
  logic                   clrSync;

  // clear synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], syncClr};
  end

  assign clrSync = syncQ[SYNC_STAGES-1];

  // divide counter, parked at terminal state during clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= LAST;
    else if (clrSync)      cnt <= LAST;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + CW'(1);
  end

  always_comb begin
    strobe.hold = clrSync;
    strobe.wrap = !clrSync && (cnt == LAST);
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

endmodule

// File: rtl/clkdiv3_dp.sv
module clkdiv3_dp
  import clkdiv3_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  output logic       cpuClk,
  output logic       periClk
);
  logic cpuQ;
  logic periQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpuQ  <= 1'b0;
      periQ <= 1'b0;
    end else begin
      cpuQ  <= strobe.wrap;
      periQ <= strobe.hold ? 1'b0 : (periQ ^ strobe.wrap);
    end
  end

  assign cpuClk  = cpuQ;
  assign periClk = periQ;

  // R2
  cpu_single_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuQ |=> !cpuQ);

  // R5
  clear_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (!cpuQ && !periQ));

endmodule

// File: rtl/clkdiv3_gen.sv
module clkdiv3_gen
  import clkdiv3_pkg::*;
#(
  parameter int DIVIDE      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic xtalClk,
  input  logic extClk,
  input  logic srcSel,
  input  logic rstN,
  input  logic syncClr,
  output logic oscOut,
  output logic cpuClk,
  output logic periClk
);
  logic       srcClk;
  divStrobe_t strobe;

  // static strap selects the divider source
  assign srcClk = srcSel ? extClk : xtalClk;
  assign oscOut = xtalClk;

  clkdiv3_ctrl #(.DIVIDE(DIVIDE), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (srcClk),
    .rstN    (rstN),
    .syncClr (syncClr),
    .strobe  (strobe)
  );

  clkdiv3_dp u_dp (
    .clk     (srcClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cpuClk  (cpuClk),
    .periClk (periClk)
  );

  // R3
  peri_step_chk: assert property (@(posedge srcClk) disable iff (!rstN)
    (periClk != $past(periClk)) |-> (cpuClk || !periClk));

endmodule

// File: tb/clkdiv3_gen_test.sv
`timescale 1ns/1ps
module clkdiv3_gen_test;
  logic xtalClk = 1'b0;
  logic extClk  = 1'b0;
  logic extEn   = 1'b1;
  logic srcSel  = 1'b0;
  logic rstN    = 1'b0;
  logic syncClr = 1'b0;
  logic oscOut, cpuClk, periClk;
  int   nRun  = 0;
  int   nFail = 0;
  logic done  = 1'b0;

  clkdiv3_gen uut (
    .xtalClk (xtalClk), .extClk (extClk), .srcSel (srcSel), .rstN (rstN),
    .syncClr (syncClr), .oscOut (oscOut), .cpuClk (cpuClk), .periClk (periClk)
  );

  always #10 xtalClk = ~xtalClk;          // 50 MHz
  initial forever begin #14; if (extEn) extClk = ~extClk; end

  task automatic check(string req, string what, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    if (srcSel) @(posedge extClk); else @(posedge xtalClk);
    #2;
  endtask

  // expected pattern i ticks after a release (i >= 1)
  task automatic checkPattern(string req, int n);
    for (int i = 1; i <= n; i++) begin
      tick();
      check(req, "cpuClk", cpuClk, (i % 3) == 1);
      check(req, "periClk", periClk, (((i - 1) / 3) % 2) == 0);
    end
  endtask

  task automatic doReset(logic strap);
    srcSel = strap; syncClr = 1'b0; extEn = 1'b1;
    #3 rstN = 1'b0;
    repeat (3) tick();
    // R9
    check("R9", "cpuClk", cpuClk, 1'b0);
    check("R9", "periClk", periClk, 1'b0);
    rstN = 1'b1;
  endtask

  task automatic testXtalPattern();
    doReset(1'b0);
    checkPattern("R1 R2 R3", 12);
  endtask

  task automatic testExtPattern();
    doReset(1'b1);
    checkPattern("R4", 12);
  endtask

  task automatic testUnselectedIgnored();
    logic c, p;
    doReset(1'b1);
    checkPattern("R4", 2);
    extEn = 1'b0;
    c = cpuClk; p = periClk;
    repeat (10) @(posedge xtalClk);
    #2;
    check("R4", "cpuClk held", cpuClk, c);
    check("R4", "periClk held", periClk, p);
    extEn = 1'b1;
    tick();
    check("R4", "cpuClk resume", cpuClk, 1'b0);
    check("R4", "periClk resume", periClk, 1'b1);
    tick();
    check("R4", "cpuClk resume", cpuClk, 1'b1);
    check("R4", "periClk resume", periClk, 1'b0);
  endtask

  task automatic testClear(int offset);
    doReset(1'b0);
    repeat (offset) tick();
    syncClr = 1'b1;
    tick(); tick();
    for (int i = 0; i < 6; i++) begin
      tick();
      check("R5", "cpuClk cleared", cpuClk, 1'b0);
      check("R5", "periClk cleared", periClk, 1'b0);
    end
    syncClr = 1'b0;
    for (int i = 0; i < 2; i++) begin
      tick();
      check("R6", "cpuClk still low", cpuClk, 1'b0);
      check("R6", "periClk still low", periClk, 1'b0);
    end
    checkPattern("R6", 9);
  endtask

  task automatic testShortPulse();
    doReset(1'b0);
    repeat (4) tick();
    syncClr = 1'b1;
    tick(); tick();
    syncClr = 1'b0;
    tick();
    check("R7", "cpuClk", cpuClk, 1'b0);
    check("R7", "periClk", periClk, 1'b0);
    tick();
    check("R7", "cpuClk", cpuClk, 1'b0);
    check("R7", "periClk", periClk, 1'b0);
    checkPattern("R7", 6);
  endtask

  task automatic testOsc();
    srcSel = 1'b1; syncClr = 1'b1;
    for (int i = 0; i < 12; i++) begin
      #7;
      check("R8", "oscOut", oscOut, xtalClk);
    end
    srcSel = 1'b0; rstN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #6;
      check("R8", "oscOut in reset", oscOut, xtalClk);
    end
    syncClr = 1'b0; rstN = 1'b1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testXtalPattern();
    testExtPattern();
    testUnselectedIgnored();
    testClear(1);
    testClear(2);
    testClear(3);
    testShortPulse();
    testOsc();
    finishRun();
  end
endmodule